// File: doc/BRIEF.md
# Masked Sequential Register Writer

This block updates a run of consecutive 32-bit device registers from two word buffers in memory. One buffer holds the new data and the other holds a bit mask for each word. Each register takes the value (old AND NOT mask) OR (data AND mask). Bits outside the mask therefore keep their value, and an all-ones mask gives a plain copy.

A request carries a register offset, a byte length, a data buffer address and a mask buffer address. It is sampled on a one-cycle `start` pulse. The block first validates the request in the cycle it is sampled. If any check fails, it reports a non-zero code without touching a register. Otherwise it walks the words one at a time. For each word it reads the register, fetches the data word, fetches the mask word and writes the merged value back. When the last write is done it pulses `done` with result 0.

Top module: `mask_reg_writer`

## Requirements
- R1: Each written register value equals (old AND NOT mask) OR (data AND mask), where old is the value read from that register earlier in the same word's sequence.
- R2: If the length, offset, data address or mask address has either of its low two bits set, the request ends with result code 1 and makes no memory or register access.
- R3: A length above 128 bytes ends with result code 2 and makes no access. A length of exactly 128 bytes (32 words) is carried out in full.
- R4: An offset of 0x420000 or more ends with result code 3 and makes no access. Offset 0x41FF80 with length 128 is accepted.
- R5: When several checks fail at once, the reported code is the lowest of the failing codes: alignment (1) before length (2) before range (3).
- R6: Word i uses register address 0x1EB00000 + offset + 4*i, data address data_base + 4*i and mask address mask_base + 4*i.
- R7: Each word makes exactly one access of each kind, in this order: register read, data fetch, mask fetch, register write. At most one request strobe is high in any cycle, and a run makes exactly length/4 register writes.
- R8: A length of 0 that passes all checks ends with result code 0 and makes no memory or register access.
- R9: `done` is a one-cycle pulse with `busy` low. `result` is 0 after a completed run. `busy` stays high from the cycle after an accepted start until the cycle of `done`.
- R10: A `start` pulse while `busy` is high is ignored. The running request finishes unchanged, and the second request causes no access.
- R11: After reset, `busy`, `done` and all request strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse; request fields are sampled with it |
| req_offset | input | 32 | Register offset in bytes from the register base |
| req_len | input | 32 | Length of the run in bytes |
| req_data_addr | input | 32 | Byte address of the data buffer |
| req_mask_addr | input | 32 | Byte address of the mask buffer |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 = success, 1 = misaligned, 2 = too long, 3 = offset out of range |
| mem_rd | output | 1 | Memory read request, held until mem_rvalid |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| reg_rd | output | 1 | Register read request, held until reg_rvalid |
| reg_we | output | 1 | Register write strobe, one cycle per word |
| reg_addr | output | 32 | Register address for read and write |
| reg_wdata | output | 32 | Merged register write value |
| reg_rvalid | input | 1 | Register read data valid |
| reg_rdata | input | 32 | Register read data |

## Verification
Two of the block's functions can coincide: several validity checks can fail on the same request, and a new start can arrive while a run is still in progress. The bench sends requests that are both misaligned and too long, and requests that are both too long and out of range. It then judges the single code that comes back against the fixed priority and confirms that the access log stays empty. A second start with different fields is pulsed in the middle of a run. It is judged by the number of register writes, by the register contents at the second request's offset, and by the absence of any further `done` pulse.

// File: rtl/msrw_pkg.sv
package msrw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RREG,
        ST_RDAT,
        ST_RMSK,
        ST_WRITE
    } msrw_state_e;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_ALIGN  = 2'd1,
        RES_LENGTH = 2'd2,
        RES_RANGE  = 2'd3
    } msrw_result_e;

    typedef struct packed {
        logic [31:0] offset;
        logic [31:0] len;
        logic [31:0] data_addr;
        logic [31:0] mask_addr;
    } msrw_req_t;

    typedef struct packed {
        logic [31:0] old_val;
        logic [31:0] data;
        logic [31:0] mask;
    } msrw_word_t;

    function automatic logic [31:0] merge_word(input msrw_word_t w);
        return (w.old_val & ~w.mask) | (w.data & w.mask);
    endfunction

    function automatic logic word_misaligned(input logic [31:0] v);
        return v[1:0] != 2'b00;
    endfunction

endpackage

// File: rtl/msrw_check.sv
module msrw_check
    import msrw_pkg::*;
#(
    parameter int unsigned MAX_LEN      = 128,
    parameter logic [31:0] OFFSET_LIMIT = 32'h0042_0000
) (
    input  msrw_req_t    req,
    output msrw_result_e verdict,
    output logic         empty
);
    logic bad_align;
    logic bad_len;
    logic bad_range;

    always_comb begin
        bad_align = word_misaligned(req.offset) || word_misaligned(req.len) ||
                    word_misaligned(req.data_addr) || word_misaligned(req.mask_addr);
        bad_len   = req.len > 32'(MAX_LEN);
        bad_range = req.offset >= OFFSET_LIMIT;
        if (bad_align)      verdict = RES_ALIGN;
        else if (bad_len)   verdict = RES_LENGTH;
        else if (bad_range) verdict = RES_RANGE;
        else                verdict = RES_OK;
        empty = req.len == 32'd0;
    end
endmodule

// File: rtl/msrw_merge.sv
module msrw_merge
    import msrw_pkg::*;
(
    input  msrw_word_t  word,
    output logic [31:0] merged
);
    always_comb merged = merge_word(word);
endmodule

// File: rtl/msrw_seq.sv
module msrw_seq
    import msrw_pkg::*;
#(
    parameter int unsigned MAX_LEN  = 128,
    parameter logic [31:0] REG_BASE = 32'h1EB0_0000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  msrw_req_t    req,
    input  msrw_result_e verdict,
    input  logic         empty,
    output logic         busy,
    output logic         done,
    output msrw_result_e result,
    output logic         mem_rd,
    output logic [31:0]  mem_addr,
    input  logic         mem_rvalid,
    input  logic [31:0]  mem_rdata,
    output logic         reg_rd,
    output logic         reg_we,
    output logic [31:0]  reg_addr,
    input  logic         reg_rvalid,
    input  logic [31:0]  reg_rdata,
    output msrw_word_t   word
);
    localparam int unsigned MAX_WORDS = MAX_LEN / 4;
    localparam int unsigned CNT_W     = $clog2(MAX_WORDS + 1);

    msrw_state_e      state;
    logic [31:0]      reg_ptr;
    logic [31:0]      data_ptr;
    logic [31:0]      mask_ptr;
    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            result   <= RES_OK;
            reg_ptr  <= '0;
            data_ptr <= '0;
            mask_ptr <= '0;
            left     <= '0;
            word     <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (verdict != RES_OK) begin
                            done   <= 1'b1;
                            result <= verdict;
                        end else if (empty) begin
                            done   <= 1'b1;
                            result <= RES_OK;
                        end else begin
                            reg_ptr  <= REG_BASE + req.offset;
                            data_ptr <= req.data_addr;
                            mask_ptr <= req.mask_addr;
                            left     <= req.len[CNT_W+1:2];
                            state    <= ST_RREG;
                        end
                    end
                end
                ST_RREG: begin
                    if (reg_rvalid) begin
                        word.old_val <= reg_rdata;
                        state        <= ST_RDAT;
                    end
                end
                ST_RDAT: begin
                    if (mem_rvalid) begin
                        word.data <= mem_rdata;
                        state     <= ST_RMSK;
                    end
                end
                ST_RMSK: begin
                    if (mem_rvalid) begin
                        word.mask <= mem_rdata;
                        state     <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    left     <= left - 1'b1;
                    reg_ptr  <= reg_ptr + 32'd4;
                    data_ptr <= data_ptr + 32'd4;
                    mask_ptr <= mask_ptr + 32'd4;
                    if (left == CNT_W'(1)) begin
                        state  <= ST_IDLE;
                        done   <= 1'b1;
                        result <= RES_OK;
                    end else begin
                        state <= ST_RREG;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = state != ST_IDLE;
        reg_rd   = state == ST_RREG;
        reg_we   = state == ST_WRITE;
        mem_rd   = (state == ST_RDAT) || (state == ST_RMSK);
        mem_addr = (state == ST_RMSK) ? mask_ptr : data_ptr;
        reg_addr = reg_ptr;
    end
endmodule

// File: rtl/mask_reg_writer.sv
module mask_reg_writer
    import msrw_pkg::*;
#(
    parameter int unsigned MAX_LEN      = 128,
    parameter logic [31:0] OFFSET_LIMIT = 32'h0042_0000,
    parameter logic [31:0] REG_BASE     = 32'h1EB0_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] req_offset,
    input  logic [31:0] req_len,
    input  logic [31:0] req_data_addr,
    input  logic [31:0] req_mask_addr,
    output logic        busy,
    output logic        done,
    output logic [1:0]  result,
    output logic        mem_rd,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        reg_rd,
    output logic        reg_we,
    output logic [31:0] reg_addr,
    output logic [31:0] reg_wdata,
    input  logic        reg_rvalid,
    input  logic [31:0] reg_rdata
);
    msrw_req_t    req;
    msrw_result_e verdict;
    msrw_result_e res_q;
    logic         empty;
    msrw_word_t   word;

    assign req = '{offset: req_offset, len: req_len,
                   data_addr: req_data_addr, mask_addr: req_mask_addr};

    msrw_check #(.MAX_LEN(MAX_LEN), .OFFSET_LIMIT(OFFSET_LIMIT)) u_check (
        .req(req), .verdict(verdict), .empty(empty)
    );

    msrw_seq #(.MAX_LEN(MAX_LEN), .REG_BASE(REG_BASE)) u_seq (
        .clk(clk), .rst(rst), .start(start), .req(req),
        .verdict(verdict), .empty(empty),
        .busy(busy), .done(done), .result(res_q),
        .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .reg_rd(reg_rd), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .word(word)
    );

    msrw_merge u_merge (.word(word), .merged(reg_wdata));

    assign result = res_q;
endmodule

// File: rtl/msrw_checker.sv
module msrw_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        mem_rd,
    input logic        reg_rd,
    input logic        reg_we,
    input logic [31:0] reg_addr,
    input logic [31:0] mem_addr
);
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, reg_rd, reg_we}));

    a_r8_access_only_when_busy: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || reg_rd || reg_we) |-> busy);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r10_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    a_r6_aligned_addr: assert property (@(posedge clk) disable iff (rst)
        (reg_we || reg_rd) |-> (reg_addr[1:0] == 2'b00));

    a_r2_aligned_fetch: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr[1:0] == 2'b00));

    a_r11_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !mem_rd && !reg_rd && !reg_we));
endmodule

bind mask_reg_writer msrw_checker u_msrw_checker (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .mem_rd(mem_rd), .reg_rd(reg_rd), .reg_we(reg_we),
    .reg_addr(reg_addr), .mem_addr(mem_addr)
);

// File: tb/mask_reg_writer_test.sv
module mask_reg_writer_test;
    localparam logic [31:0] RBASE = 32'h1EB0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] req_offset = '0, req_len = '0, req_data_addr = '0, req_mask_addr = '0;
    logic        busy, done, mem_rd, reg_rd, reg_we;
    logic [1:0]  result;
    logic [31:0] mem_addr, reg_addr, reg_wdata;
    logic        mem_rvalid = 1'b0, reg_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0, reg_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem  [0:1023];
    logic [31:0] regs [0:255];
    int          log_kind [0:1023];
    logic [31:0] log_addr [0:1023];
    int          log_n = 0;
    int          wr_n = 0;

    always #2.5 clk = ~clk;

    mask_reg_writer uut (
        .clk(clk), .rst(rst), .start(start),
        .req_offset(req_offset), .req_len(req_len),
        .req_data_addr(req_data_addr), .req_mask_addr(req_mask_addr),
        .busy(busy), .done(done), .result(result),
        .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .reg_rd(reg_rd), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata)
    );

    function automatic int ridx(input logic [31:0] a);
        return int'((a >> 2) & 32'd255);
    endfunction

    function automatic int midx(input logic [31:0] a);
        return int'((a >> 2) & 32'd1023);
    endfunction

    always @(posedge clk) begin
        reg_rvalid <= reg_rd && !reg_rvalid;
        reg_rdata  <= regs[ridx(reg_addr)];
        mem_rvalid <= mem_rd && !mem_rvalid;
        mem_rdata  <= mem[midx(mem_addr)];
        if (reg_we) begin
            regs[ridx(reg_addr)] <= reg_wdata;
            wr_n <= wr_n + 1;
        end
        if (!rst && log_n < 1020) begin
            if (reg_rd && !reg_rvalid) begin
                log_kind[log_n] <= 0; log_addr[log_n] <= reg_addr; log_n <= log_n + 1;
            end else if (mem_rd && !mem_rvalid) begin
                log_kind[log_n] <= 1; log_addr[log_n] <= mem_addr; log_n <= log_n + 1;
            end else if (reg_we) begin
                log_kind[log_n] <= 3; log_addr[log_n] <= reg_addr; log_n <= log_n + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] off, input logic [31:0] len,
                         input logic [31:0] da, input logic [31:0] ma,
                         output logic [1:0] res, output int cyc);
        @(negedge clk);
        start = 1'b1; req_offset = off; req_len = len;
        req_data_addr = da; req_mask_addr = ma;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 2000) begin
            checks++; errors++;
            $display("FAIL R9: actual=timeout expected=done");
        end
        res = result;
    endtask

    task automatic t_reset();
        chk("R11 busy", 32'(busy), 0);
        chk("R11 done", 32'(done), 0);
        chk("R11 strobes", 32'({mem_rd, reg_rd, reg_we}), 0);
    endtask

    task automatic run_masked(input logic [31:0] off, input int words,
                              input logic [31:0] da, input logic [31:0] ma, input string tag);
        logic [31:0] exp [0:31];
        logic [1:0]  res;
        int          cyc, l0, ok;
        for (int i = 0; i < words; i++) begin
            logic [31:0] o, d, m;
            o = regs[ridx(RBASE + off + 32'(4 * i))];
            d = mem[midx(da + 32'(4 * i))];
            m = mem[midx(ma + 32'(4 * i))];
            exp[i] = (o & ~m) | (d & m);
        end
        l0 = log_n;
        issue(off, 32'(4 * words), da, ma, res, cyc);
        chk({tag, " R9 result"}, 32'(res), 0);
        chk({tag, " R9 busy low at done"}, 32'(busy), 0);
        @(negedge clk);
        chk({tag, " R9 done pulse"}, 32'(done), 0);
        ok = 1;
        for (int i = 0; i < words; i++)
            if (regs[ridx(RBASE + off + 32'(4 * i))] !== exp[i]) ok = 0;
        chk({tag, " R1 merged values"}, 32'(ok), 1);
        chk({tag, " R7 access count"}, 32'(log_n - l0), 32'(4 * words));
        ok = 1;
        for (int i = 0; i < words; i++) begin
            int b;
            b = l0 + 4 * i;
            if (log_kind[b] != 0 || log_addr[b] != RBASE + off + 32'(4 * i)) ok = 0;
            if (log_kind[b+1] != 1 || log_addr[b+1] != da + 32'(4 * i)) ok = 0;
            if (log_kind[b+2] != 1 || log_addr[b+2] != ma + 32'(4 * i)) ok = 0;
            if (log_kind[b+3] != 3 || log_addr[b+3] != RBASE + off + 32'(4 * i)) ok = 0;
        end
        chk({tag, " R6 R7 order and addresses"}, 32'(ok), 1);
    endtask

    task automatic t_basic();
        run_masked(32'h40, 4, 32'h100, 32'h800, "basic");
    endtask

    task automatic t_full_edge();
        for (int i = 0; i < 32; i++) mem[midx(32'h900 + 32'(4 * i))] = 32'hFFFF_FFFF;
        run_masked(32'h0041_FF80, 32, 32'h200, 32'h900, "R3 R4 full length at top offset");
    endtask

    task automatic t_zero_len();
        logic [1:0] res;
        int cyc, l0;
        l0 = log_n;
        issue(32'h10, 0, 32'h100, 32'h800, res, cyc);
        chk("R8 result", 32'(res), 0);
        chk("R8 latency", 32'(cyc), 1);
        repeat (2) @(negedge clk);
        chk("R8 no access", 32'(log_n - l0), 0);
    endtask

    task automatic err_case(input logic [31:0] off, input logic [31:0] len,
                            input logic [31:0] da, input logic [31:0] ma,
                            input logic [1:0] code, input string tag);
        logic [1:0] res;
        int cyc, l0;
        l0 = log_n;
        issue(off, len, da, ma, res, cyc);
        chk({tag, " code"}, 32'(res), 32'(code));
        repeat (3) @(negedge clk);
        chk({tag, " no access"}, 32'(log_n - l0), 0);
        chk({tag, " idle"}, 32'(busy), 0);
    endtask

    task automatic t_errors();
        err_case(32'h42, 8, 32'h100, 32'h800, 1, "R2 offset");
        err_case(32'h40, 6, 32'h100, 32'h800, 1, "R2 length");
        err_case(32'h40, 8, 32'h101, 32'h800, 1, "R2 data addr");
        err_case(32'h40, 8, 32'h100, 32'h803, 1, "R2 mask addr");
        err_case(32'h40, 32'h84, 32'h100, 32'h800, 2, "R3 too long");
        err_case(32'h0042_0000, 8, 32'h100, 32'h800, 3, "R4 out of range");
        err_case(32'h40, 32'h86, 32'h100, 32'h800, 1, "R5 align over length");
        err_case(32'h0042_0000, 32'h100, 32'h100, 32'h800, 2, "R5 length over range");
        err_case(32'h0050_0001, 8, 32'h100, 32'h800, 1, "R5 align over range");
    endtask

    task automatic t_busy_start();
        logic [31:0] snap [0:3];
        int w0, cyc;
        for (int i = 0; i < 4; i++) snap[i] = regs[ridx(RBASE + 32'h300 + 32'(4 * i))];
        w0 = wr_n;
        @(negedge clk);
        start = 1'b1; req_offset = 32'h80; req_len = 16;
        req_data_addr = 32'h100; req_mask_addr = 32'h800;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; req_offset = 32'h300; req_len = 16;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
        chk("R10 result", 32'(result), 0);
        repeat (20) begin
            @(negedge clk);
            chk("R10 no second run", 32'({busy, done}), 0);
        end
        chk("R10 write count", 32'(wr_n - w0), 4);
        for (int i = 0; i < 4; i++)
            chk("R10 second offset untouched", regs[ridx(RBASE + 32'h300 + 32'(4 * i))], snap[i]);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA55A_0000 ^ (32'(i) * 32'h0101_0113);
        for (int i = 0; i < 256; i++) regs[i] = 32'h3C3C_0000 + 32'(i) * 32'h0001_0F01;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero_len();
        t_errors();
        t_full_edge();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule